// File: doc/BRIEF.md
# Transmit Descriptor Walking DMA Engine

This block is a bus-master engine that sends frames described by a chain of descriptors in system memory. Software builds each descriptor (length, first/last segment marks, an ownership mark, a pointer to the next descriptor and a pointer to the frame buffer), loads the address of the first descriptor, and writes a start command. The engine reads the descriptor and checks that hardware owns it. It then reads the buffer word by word and sends the bytes on a 32-bit AXI4-Stream master. Finally it writes the first descriptor word back with ownership returned to software and moves on to the next descriptor.

When the engine meets a descriptor that software still owns, it either stops or, with polling enabled, re-reads that descriptor after a fixed number of clock cycles until software hands it over. A descriptor that marks the start of a frame but not its end is refused: a sticky error flag is set and nothing is sent. Software controls the engine through two registers. One is a control/status word with bit-coded command strobes; the other holds the current-descriptor address.

Top module: `txdesc_dma`

## Requirements
- R1: While reset is low and after its release, the status word reads 0, the current-descriptor address reads 0, `m_tvalid` is 0 and `mem_req` is 0.
- R2: With `reg_sel`=0 a register write is a command: bit 4 sets the run request, bit 5 clears it (bit 5 wins when both are set), bit 7 is stored as the poll enable, and bit 1 clears the done flag. Reading with `reg_sel`=0 returns bit 0 = engine active, bit 2 = done flag, bit 3 = error flag, bit 7 = poll enable, all other bits 0. With `reg_sel`=1 a write loads the current-descriptor address with bits 4:0 forced to 0, and a read returns it.
- R3: A descriptor is read as three 32-bit words at its address +0, +4 and +8. Word 0 holds the length in bytes in bits 15:0, last-segment in bit 29, first-segment in bit 30 and hardware ownership in bit 31. Word 1 is the next-descriptor address and word 2 is the buffer address. All memory addresses the engine issues are word aligned.
- R4: An owned frame of L>0 bytes gives ceil(L/4) beats. The beats carry the buffer words in rising address order, with byte 0 in bits 7:0. `m_tlast` is set only on the final beat. `m_tkeep` is 4'hF on every beat except a final beat with L mod 4 != 0, which carries the low L mod 4 bits set.
- R5: A beat with `m_tvalid` high and `m_tready` low keeps data, keep and last unchanged until accepted. No beat is lost or repeated, and at most one memory read is outstanding.
- R6: After the final beat is accepted, the engine makes exactly one memory write to the descriptor address with word 0 as read but bit 31 cleared. It then sets the done flag, takes word 1 (bits 4:0 forced to 0) as the current address and, while run is requested, fetches that descriptor.
- R7: An owned descriptor with length 0 produces no beats but is still written back as in R6.
- R8: A fetched descriptor with bit 31 clear and polling off makes the engine go idle and clear the run request, with no write and the current address unchanged.
- R9: With polling on, a descriptor with bit 31 clear is fetched again POLL_CYCLES+1 cycles after the ownership check, repeatedly, and is sent once software sets bit 31. The engine stays active meanwhile.
- R10: An owned descriptor with bit 30 set and bit 29 clear sets the sticky error flag. It produces no beats and no write, leaves the current address unchanged and makes the engine go idle.
- R11: A stop command during a frame lets that frame finish and be written back, after which the engine goes idle without fetching the next descriptor. A stop command during a poll wait makes the engine idle at once.
- R12: A done-flag set and a clear command in the same cycle leave the flag set. The error flag is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control/status, 1 current-descriptor address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| mem_req | output | 1 | Memory request, taken in the cycle it is high |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid for the outstanding read |
| mem_rdata | input | 32 | Read data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream data |
| m_tkeep | output | 4 | Stream byte enables |
| m_tlast | output | 1 | Final beat of a frame |

## Verification
The bench memory answers every read one cycle after the request cycle, so a beat is offered in the cycle after its read data arrives. The write-back request appears in the cycle after the final beat is accepted, and a poll re-fetch comes POLL_CYCLES+1 cycles after the ownership check. The reference model queues the expected beats and write-backs from the descriptors it builds. Each offered beat and each write request is compared in the clock where it is seen, so a wrong value, an extra event or a missing one (found by the empty-queue checks) fails in its own cycle. Register results are read only after bounded waits for the engine to go idle, or a fixed settle of several cycles after a command, which covers the one-cycle delay from command to state change.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_STREAM, S_WBACK, S_POLL
  } txd_state_e;

  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 30;
  localparam int LAST_BIT  = 29;
  localparam int LEN_W     = 16;
  localparam int ALIGN_W   = 5;
  localparam int LANES     = 4;

  localparam int CMD_CLR_DONE = 1;
  localparam int CMD_START    = 4;
  localparam int CMD_STOP     = 5;
  localparam int CMD_POLL     = 7;

  localparam int ST_ACTIVE = 0;
  localparam int ST_DONE   = 2;
  localparam int ST_ERR    = 3;
endpackage

// File: rtl/txd_csr.sv
module txd_csr
  import txd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  input  logic [31:0] cur_addr,
  input  logic        active,
  input  logic        halt,
  input  logic        set_done,
  input  logic        set_err,
  output logic        run,
  output logic        poll_en,
  output logic [31:0] rd_data
);
  logic cmd_wr;
  logic run_q, run_d, poll_q, done_q, done_d, err_q;
  logic unused_wbits;

  assign cmd_wr = wr_en && !wr_sel;
  assign unused_wbits = ^{wr_data[31:8], wr_data[6], wr_data[3:2], wr_data[0]};

  always_comb begin
    run_d = run_q;
    if (cmd_wr && wr_data[CMD_STOP])       run_d = 1'b0;
    else if (cmd_wr && wr_data[CMD_START]) run_d = 1'b1;
    else if (halt)                         run_d = 1'b0;
    done_d = done_q;
    if (set_done)                               done_d = 1'b1;
    else if (cmd_wr && wr_data[CMD_CLR_DONE])   done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      poll_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (cmd_wr)  poll_q <= wr_data[CMD_POLL];
      if (set_err) err_q  <= 1'b1;
    end
  end

  assign run     = run_q;
  assign poll_en = poll_q;

  always_comb begin
    rd_data = '0;
    if (rd_sel) begin
      rd_data = cur_addr;
    end else begin
      rd_data[ST_ACTIVE] = active;
      rd_data[ST_DONE]   = done_q;
      rd_data[ST_ERR]    = err_q;
      rd_data[CMD_POLL]  = poll_q;
    end
  end
endmodule

// File: rtl/txd_poll_timer.sv
module txd_poll_timer #(
  parameter int POLL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic count_en,
  output logic expired
);
  localparam int CNT_W = (POLL_CYCLES < 2) ? 1 : $clog2(POLL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= LOAD_VAL;
    else if (count_en && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/txd_out_stage.sv
module txd_out_stage
  import txd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      ld_data,
  input  logic [LANES-1:0] ld_keep,
  input  logic             ld_last,
  input  logic             ready,
  output logic             valid,
  output logic [31:0]      data,
  output logic [LANES-1:0] keep,
  output logic             last
);
  logic valid_q, valid_d;

  assign valid_d = load || (valid_q && !ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data    <= '0;
      keep    <= '0;
      last    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        data <= ld_data;
        keep <= ld_keep;
        last <= ld_last;
      end
    end
  end

  assign valid = valid_q;
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int POLL_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic [31:0] m_tdata,
  output logic [3:0]  m_tkeep,
  output logic        m_tlast
);
  localparam int PTR_W = 32 - ALIGN_W;

  txd_state_e state_q, state_d;
  logic [PTR_W-1:0] cur_q, next_q;
  logic [31:0]      word0_q, bufp_q, rd_ptr_q;
  logic [LEN_W-1:0] rem_q;
  logic [1:0]       idx_q;
  logic             pend_q;
  logic [LANES-1:0] pkeep_q;
  logic             plast_q;

  logic run, poll_en, halt, set_done, set_err, poll_load, poll_expired;
  logic issue, slot_free, out_load, final_beat, active;
  logic [31:0] cur_addr;
  logic unused_bits;

  assign cur_addr    = {cur_q, {ALIGN_W{1'b0}}};
  assign active      = (state_q != S_IDLE);
  assign slot_free   = !m_tvalid || m_tready;
  assign final_beat  = m_tvalid && m_tready && m_tlast;
  assign out_load    = mem_rvalid && (state_q == S_STREAM);
  assign unused_bits = ^{reg_wdata[ALIGN_W-1:0], mem_rdata[ALIGN_W-1:0]};

  function automatic logic [LANES-1:0] tail_keep(input logic [LEN_W-1:0] rem);
    if (rem >= LEN_W'(LANES)) return '1;
    return LANES'((5'd1 << rem[1:0]) - 5'd1);
  endfunction

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_addr;
    mem_wdata = word0_q & ~(32'd1 << OWN_BIT);
    issue     = 1'b0;
    halt      = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    poll_load = 1'b0;
    unique case (state_q)
      S_IDLE: if (run) state_d = S_FETCH;
      S_FETCH: begin
        if (!pend_q) begin
          mem_req  = 1'b1;
          mem_addr = {cur_q, 1'b0, idx_q, 2'b00};
        end
        if (mem_rvalid && idx_q == 2'd2) state_d = S_CHECK;
      end
      S_CHECK: begin
        if (!run) begin
          state_d = S_IDLE;
        end else if (!word0_q[OWN_BIT]) begin
          if (poll_en) begin
            state_d   = S_POLL;
            poll_load = 1'b1;
          end else begin
            state_d = S_IDLE;
            halt    = 1'b1;
          end
        end else if (word0_q[FIRST_BIT] && !word0_q[LAST_BIT]) begin
          state_d = S_IDLE;
          halt    = 1'b1;
          set_err = 1'b1;
        end else if (word0_q[LEN_W-1:0] == '0) begin
          state_d = S_WBACK;
        end else begin
          state_d = S_STREAM;
        end
      end
      S_STREAM: begin
        if (!pend_q && rem_q != '0 && slot_free) begin
          mem_req  = 1'b1;
          mem_addr = rd_ptr_q;
          issue    = 1'b1;
        end
        if (final_beat) state_d = S_WBACK;
      end
      S_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        set_done = 1'b1;
        state_d  = run ? S_FETCH : S_IDLE;
      end
      S_POLL: begin
        if (!run)              state_d = S_IDLE;
        else if (poll_expired) state_d = S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      next_q   <= '0;
      word0_q  <= '0;
      bufp_q   <= '0;
      rd_ptr_q <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      pend_q   <= 1'b0;
      pkeep_q  <= '0;
      plast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (pend_q && !mem_rvalid) || (mem_req && !mem_we);
      if (state_q == S_FETCH && mem_rvalid) begin
        idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
        case (idx_q)
          2'd0:    word0_q <= mem_rdata;
          2'd1:    next_q  <= mem_rdata[31:ALIGN_W];
          default: bufp_q  <= mem_rdata;
        endcase
      end
      if (state_q == S_CHECK) begin
        rd_ptr_q <= {bufp_q[31:2], 2'b00};
        rem_q    <= word0_q[LEN_W-1:0];
      end
      if (issue) begin
        rd_ptr_q <= rd_ptr_q + 32'd4;
        rem_q    <= (rem_q > LEN_W'(LANES)) ? rem_q - LEN_W'(LANES) : '0;
        pkeep_q  <= tail_keep(rem_q);
        plast_q  <= (rem_q <= LEN_W'(LANES));
      end
      if (state_q == S_WBACK)            cur_q <= next_q;
      else if (reg_wr && reg_sel)        cur_q <= reg_wdata[31:ALIGN_W];
    end
  end

  txd_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .rd_sel(reg_sel), .cur_addr(cur_addr), .active(active), .halt(halt),
    .set_done(set_done), .set_err(set_err), .run(run), .poll_en(poll_en),
    .rd_data(reg_rdata)
  );

  txd_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_n), .load(poll_load), .count_en(state_q == S_POLL),
    .expired(poll_expired)
  );

  txd_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(out_load), .ld_data(mem_rdata),
    .ld_keep(pkeep_q), .ld_last(plast_q), .ready(m_tready),
    .valid(m_tvalid), .data(m_tdata), .keep(m_tkeep), .last(m_tlast)
  );
endmodule

// File: rtl/txdesc_dma_checker.sv
module txdesc_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        pend,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic [31:0] m_tdata,
  input logic [3:0]  m_tkeep,
  input logic        m_tlast
);
  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

  assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !(mem_req && !mem_we));

  assert_full_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> m_tkeep == 4'hF);

  assert_low_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tkeep[0] && ((m_tkeep & (m_tkeep + 4'd1)) == 4'd0));

  assert_own_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !m_tvalid);
endmodule

bind txdesc_dma txdesc_dma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .pend(pend_q),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tkeep(m_tkeep), .m_tlast(m_tlast)
);

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic m_tvalid, m_tready, m_tlast;
  logic [31:0] m_tdata;
  logic [3:0] m_tkeep;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_dma #(.POLL_CYCLES(POLL)) u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast)
  );

  logic [31:0] mem [0:1023];
  logic [36:0] exp_beats[$];
  logic [63:0] exp_wr[$];
  int checks = 0, errors = 0, beats_seen = 0;
  bit rdy_rand = 1'b0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and event comparison, once per cycle at the falling edge
  initial begin
    bit pv;
    logic [9:0] pa;
    pv = 1'b0; pa = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (m_tvalid && m_tready) begin
          beats_seen++;
          if (exp_beats.size() == 0) check("R4 unexpected beat", 64'(m_tdata), 64'hBAD);
          else check("R4 beat {last,keep,data}", 64'({m_tlast, m_tkeep, m_tdata}), 64'(exp_beats.pop_front()));
        end
        if (mem_req && mem_we) begin
          if (exp_wr.size() == 0) check("R10/R8 unexpected write", {mem_addr, mem_wdata}, 64'hBAD);
          else check("R6 writeback {addr,data}", {mem_addr, mem_wdata}, exp_wr.pop_front());
          mem[mem_addr[11:2]] = mem_wdata;
        end
      end
      mem_rvalid = pv;
      mem_rdata  = mem[pa];
      pv = rst_n && mem_req && !mem_we;
      pa = mem_addr[11:2];
    end
  end

  initial begin
    m_tready = 1'b1;
    forever begin
      @(posedge clk); #1;
      m_tready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic push_frame(input int a);
    logic [31:0] w0;
    int len, bufa;
    w0 = mem[a >> 2];
    len = int'(w0[15:0]);
    bufa = int'(mem[(a >> 2) + 2]);
    for (int i = 0; i < (len + 3) / 4; i++) begin
      int r;
      logic [3:0] k;
      r = len - 4 * i;
      k = (r >= 4) ? 4'hF : 4'((1 << r) - 1);
      exp_beats.push_back({(r <= 4), k, mem[(bufa >> 2) + i]});
    end
    exp_wr.push_back({32'(a), w0 & 32'h7FFF_FFFF});
  endtask

  task automatic make_desc(input int a, input int len, input bit f, input bit l, input bit own,
                           input int nxt, input int bufa, input int seed, input bit expect_it);
    mem[a >> 2] = {own, f, l, 13'd0, 16'(len)};
    mem[(a >> 2) + 1] = 32'(nxt);
    mem[(a >> 2) + 2] = 32'(bufa);
    for (int k = 3; k < 8; k++) mem[(a >> 2) + k] = 32'hDEAD_0000 | 32'(k);
    for (int i = 0; i < (len + 3) / 4; i++)
      mem[(bufa >> 2) + i] = 32'h5A00_0000 ^ (32'(seed) << 16) ^ (32'(i) * 32'h0101_0101);
    if (expect_it) push_frame(a);
  endtask

  task automatic reg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input bit sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n;
    repeat (3) @(negedge clk);
    n = 0;
    s = 32'h1;
    while (s[0] && n < 3000) begin reg_read(1'b0, s); n++; end
    check({tag, " engine idle"}, 64'(s[0]), 64'd0);
  endtask

  task automatic check_drained(input string tag);
    check({tag, " pending beats"}, 64'(exp_beats.size()), 64'd0);
    check({tag, " pending writes"}, 64'(exp_wr.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int b0, n;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held and after release
    reg_read(1'b0, s); check("R1 status in reset", 64'(s), 64'd0);
    check("R1 tvalid/mem_req in reset", 64'({m_tvalid, mem_req}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reg_read(1'b0, s); check("R1 status after reset", 64'(s), 64'd0);
    reg_read(1'b1, s); check("R1 address after reset", 64'(s), 64'd0);

    // R2: address low bits forced to zero
    reg_write(1'b1, 32'h0000_013F);
    reg_read(1'b1, s); check("R2 address masking", 64'(s), 64'h120);

    // R3 R4 R5 R6 R8: ring of three frames, random backpressure
    rdy_rand = 1'b1;
    make_desc(32'h100, 10, 1, 1, 1, 32'h120, 32'h400, 1, 1);
    make_desc(32'h120, 8, 1, 1, 1, 32'h140, 32'h420, 2, 1);
    make_desc(32'h140, 3, 1, 1, 1, 32'h100, 32'h440, 3, 1);
    reg_write(1'b1, 32'h100);
    reg_write(1'b0, 32'h10);
    wait_idle("R6 ring");
    check_drained("R4 R6 ring");
    reg_read(1'b1, s); check("R8 address not advanced past unowned", 64'(s), 64'h100);
    reg_read(1'b0, s); check("R6 done set, R8 idle", 64'(s), 64'h4);

    // R12 R2: done clear, poll readback, stop wins over start
    reg_write(1'b0, 32'h02);
    reg_read(1'b0, s); check("R12 done cleared", 64'(s), 64'h0);
    reg_write(1'b0, 32'h80);
    reg_read(1'b0, s); check("R2 poll enable readback", 64'(s), 64'h80);
    reg_write(1'b0, 32'h30);
    repeat (4) @(negedge clk);
    reg_read(1'b0, s); check("R2 stop wins over start", 64'(s), 64'h0);

    // R4 R7: length corner cases, full throughput
    rdy_rand = 1'b0;
    make_desc(32'h200, 1, 1, 1, 1, 32'h220, 32'h500, 4, 1);
    make_desc(32'h220, 4, 1, 1, 1, 32'h240, 32'h520, 5, 1);
    make_desc(32'h240, 5, 1, 1, 1, 32'h260, 32'h540, 6, 1);
    make_desc(32'h260, 7, 0, 1, 1, 32'h280, 32'h560, 7, 1);
    make_desc(32'h280, 0, 1, 1, 1, 32'h200, 32'h580, 8, 1);
    reg_write(1'b1, 32'h200);
    reg_write(1'b0, 32'h10);
    wait_idle("R7 lengths");
    check_drained("R4 R7 lengths");
    reg_read(1'b1, s); check("R7 address back at first", 64'(s), 64'h200);

    // R10: first without last
    make_desc(32'h300, 8, 1, 0, 1, 32'h320, 32'h5C0, 9, 0);
    reg_write(1'b1, 32'h300);
    reg_write(1'b0, 32'h10);
    wait_idle("R10 error");
    check_drained("R10 error");
    reg_read(1'b0, s); check("R10 error flag set", 64'(s[3]), 64'd1);
    reg_read(1'b1, s); check("R10 address unchanged", 64'(s), 64'h300);
    reg_write(1'b0, 32'h02);
    reg_read(1'b0, s); check("R12 error flag sticky", 64'(s[3]), 64'd1);

    // R9 R11: polling on an unowned descriptor
    make_desc(32'h320, 6, 1, 1, 0, 32'h340, 32'h600, 10, 0);
    make_desc(32'h340, 6, 1, 1, 0, 32'h360, 32'h620, 11, 0);
    reg_write(1'b1, 32'h320);
    reg_write(1'b0, 32'h90);
    repeat (3 * POLL) @(negedge clk);
    reg_read(1'b0, s); check("R9 active while polling", 64'(s[0]), 64'd1);
    check("R9 no beats while unowned", 64'(beats_seen == 0 ? 0 : exp_beats.size()), 64'd0);
    mem[32'h320 >> 2][31] = 1'b1;
    push_frame(32'h320);
    n = 0;
    while ((exp_beats.size() != 0 || exp_wr.size() != 0) && n < 4 * POLL + 40) begin
      @(negedge clk); n++;
    end
    check_drained("R9 poll pickup");
    repeat (2 * POLL) @(negedge clk);
    reg_read(1'b0, s); check("R9 still polling next", 64'(s[0]), 64'd1);
    reg_write(1'b0, 32'h20);
    repeat (3) @(negedge clk);
    reg_read(1'b0, s); check("R11 stop in poll wait", 64'(s[0]), 64'd0);
    reg_read(1'b1, s); check("R11 address at polled descriptor", 64'(s), 64'h340);

    // R11: stop during a frame
    rdy_rand = 1'b1;
    make_desc(32'h380, 40, 1, 1, 1, 32'h3A0, 32'h700, 12, 1);
    make_desc(32'h3A0, 8, 1, 1, 1, 32'h380, 32'h740, 13, 0);
    reg_write(1'b1, 32'h380);
    b0 = beats_seen;
    reg_write(1'b0, 32'h10);
    n = 0;
    while (beats_seen == b0 && n < 500) begin @(negedge clk); n++; end
    reg_write(1'b0, 32'h20);
    wait_idle("R11 stop");
    check_drained("R11 frame finished");
    reg_read(1'b1, s); check("R11 address at next", 64'(s), 64'h3A0);
    check("R11 next descriptor untouched", 64'(mem[32'h3A0 >> 2][31]), 64'd1);

    rdy_rand = 1'b0;
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule